// File: doc/BRIEF.md
# Configuration Header BAR Decoder

This block is the slice of a device's configuration header that owns the command register and a small set of base address registers (BARs). Software reaches it through a dword-addressed configuration port. Through that port it enables or disables memory-space and I/O-space decoding, and it programs a base address into each BAR. Each BAR is fixed when the design is built in two ways: it decodes either I/O space or memory space, and its window is a power of two in size. Neither can be changed by a write.

The low bits of each BAR are read-only. They return the space type and zeros up to the window size. Software finds a window's size and type by saving the BAR, writing all ones, reading back the mask, and then writing the saved value again.

On the bus side, each access presents a space flag and a 32-bit address. One cycle later the block raises a per-BAR hit for every BAR whose type matches the space, whose space enable is set, and whose programmed base equals the address bits above the window size. Configuration accesses are sequenced by a three-state controller.

- Idle: the controller waits for a request.
- Read: entered from Idle on a read request (transition `T_RD_START`).
- Write: entered from Idle on a write request (transition `T_WR_START`).
- Read and Write each return to Idle after one cycle (transitions `T_RD_DONE` and `T_WR_DONE`), and the acknowledge is registered on that return.

Top module: `cfg_bar_decode`

## Requirements
- R1: The command register sits at dword index 1 (byte offset 0x04). Bit 0 is the I/O-space enable and bit 1 is the memory-space enable. Both reset to 0, and all other bits read 0.
- R2: BAR n sits at dword index 4+n (byte offset 0x10 + 4n) for n = 0 to NUM_BARS-1. Every other dword index except 1 reads 0 and ignores writes, so the command register and the BARs keep their values.
- R3: Bit 0 of a BAR reads 1 for an I/O BAR and 0 for a memory BAR. Bits 3:1 of a memory BAR read 000 and bit 1 of an I/O BAR reads 0. Writes never change these bits.
- R4: BAR bits below the window's log2 size read 0 whatever was written. Writing 0xFFFFFFFF therefore reads back (0xFFFFFFFF << log2size) OR the type bit.
- R5: Writing a base value that is aligned to the window reads back that value plus the type bit. After a saved base is restored following a size probe, the BAR decodes exactly the original range again.
- R6: A memory access (acc_is_io = 0) with the memory enable set raises bar_hit[n] in the cycle after acc_valid, for each memory BAR n whose base equals acc_addr[31:log2size]. Addresses one below the base and one past the window end give no hit.
- R7: An I/O access (acc_is_io = 1) with the I/O enable set raises bar_hit[n] under the same base-match rule, for I/O BARs only.
- R8: With the memory enable at 0, no memory access causes a hit. With the I/O enable at 0, no I/O access causes a hit. An access never hits a BAR of the other space type.
- R9: bar_hit is all zeros in the cycle after any cycle in which acc_valid is 0.
- R10: A cfg_req accepted in Idle produces a one-cycle cfg_ack two clock edges later. On a read, cfg_rdata holds the addressed value while cfg_ack is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Configuration request pulse |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_dw | input | 6 | Dword index into the 256-byte header |
| cfg_wdata | input | 32 | Write data |
| cfg_ack | output | 1 | Request completed |
| cfg_rdata | output | 32 | Read data, valid with cfg_ack |
| acc_valid | input | 1 | Bus access present |
| acc_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| acc_addr | input | 32 | Access address |
| bar_hit | output | NUM_BARS | Per-BAR claim, one cycle after the access |

## Verification
The bench sweeps every enable combination against both spaces at the addresses just below, at, inside, at the last byte of, and just past each window. A decoder that compared one bit too many or too few would then miss the last byte or claim the byte past the end. Size probes with all ones and all zeros catch low bits that are writable, and a type bit that can be overwritten would show up as a changed space type. A sweep over every unimplemented dword catches aliasing, such as a truncated index decode that wrote a BAR or the command register through a neighbouring offset. The save, probe and restore sequence catches a base that does not come back intact, which would leave the device claiming the wrong range.

// File: rtl/cfg_bar_pkg.sv
package cfg_bar_pkg;

    localparam int unsigned DW_IDX_W  = 6;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned MAX_BARS  = 6;
    localparam int unsigned LOG2_FW   = 5;

    localparam logic [DW_IDX_W-1:0] CMD_DW_IDX  = 6'd1;
    localparam logic [DW_IDX_W-1:0] BAR0_DW_IDX = 6'd4;

    localparam int unsigned CMD_IO_BIT  = 0;
    localparam int unsigned CMD_MEM_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } cfg_state_e;

endpackage

// File: rtl/cfg_access_fsm.sv
module cfg_access_fsm
    import cfg_bar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_req,
    input  logic                 cfg_we,
    input  logic [DW_IDX_W-1:0]  cfg_dw,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic [DATA_W-1:0]    rd_word,
    output logic [DW_IDX_W-1:0]  lat_dw,
    output logic [DATA_W-1:0]    lat_wdata,
    output logic                 wr_stb,
    output logic                 cfg_ack,
    output logic [DATA_W-1:0]    cfg_rdata
);

    cfg_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_req && cfg_we)       state_d = ST_WRITE; // T_WR_START
                else if (cfg_req)            state_d = ST_READ;  // T_RD_START
            end
            ST_READ:  state_d = ST_IDLE;                         // T_RD_DONE
            ST_WRITE: state_d = ST_IDLE;                         // T_WR_DONE
            default:  state_d = ST_IDLE;
        endcase
    end

    // request capture, only in idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_dw    <= '0;
            lat_wdata <= '0;
        end else if (state_q == ST_IDLE && cfg_req) begin
            lat_dw    <= cfg_dw;
            lat_wdata <= cfg_wdata;
        end
    end

    assign wr_stb = (state_q == ST_WRITE);

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_ack   <= 1'b0;
            cfg_rdata <= '0;
        end else begin
            unique case (state_q)
                ST_READ: begin
                    cfg_ack   <= 1'b1;
                    cfg_rdata <= rd_word;
                end
                ST_WRITE: begin
                    cfg_ack   <= 1'b1;
                    cfg_rdata <= '0;
                end
                default: begin
                    cfg_ack   <= 1'b0;
                    cfg_rdata <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfg_bar_pkg::*;
#(
    parameter bit          IS_IO    = 1'b0,
    parameter int unsigned SIZE_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val,
    input  logic              acc_valid,
    input  logic              acc_is_io,
    input  logic [DATA_W-1:0] acc_addr,
    input  logic              space_en,
    output logic              match
);

    localparam int unsigned BASE_W = DATA_W - SIZE_LOG2;
    localparam logic [DATA_W-1:0] TYPE_WORD = IS_IO ? 32'd1 : 32'd0;

    logic [BASE_W-1:0] base_q;
    logic              unused_wlow;
    logic              unused_alow;

    assign unused_wlow = ^wdata[SIZE_LOG2-1:0];
    assign unused_alow = ^acc_addr[SIZE_LOG2-1:0];

    // only the bits above the window size hold state
    always_ff @(posedge clk) begin
        if (!rst_n)     base_q <= '0;
        else if (wr_en) base_q <= wdata[DATA_W-1:SIZE_LOG2];
    end

    assign rd_val = {base_q, {SIZE_LOG2{1'b0}}} | TYPE_WORD;

    assign match = acc_valid && space_en && (acc_is_io == IS_IO)
                && (acc_addr[DATA_W-1:SIZE_LOG2] == base_q);

endmodule

// File: rtl/cfg_bar_decode.sv
module cfg_bar_decode
    import cfg_bar_pkg::*;
#(
    parameter int unsigned                    NUM_BARS    = 3,
    parameter logic [NUM_BARS-1:0]            BAR_IO_MASK = 3'b010,
    parameter logic [NUM_BARS*LOG2_FW-1:0]    BAR_LOG2    = {5'd12, 5'd4, 5'd8}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_req,
    input  logic                 cfg_we,
    input  logic [DW_IDX_W-1:0]  cfg_dw,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic                 cfg_ack,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 acc_valid,
    input  logic                 acc_is_io,
    input  logic [DATA_W-1:0]    acc_addr,
    output logic [NUM_BARS-1:0]  bar_hit
);

    logic [DW_IDX_W-1:0] lat_dw;
    logic [DATA_W-1:0]   lat_wdata;
    logic                wr_stb;
    logic [DATA_W-1:0]   rd_word;
    logic                io_en_q;
    logic                mem_en_q;
    logic [DATA_W-1:0]   bar_rd [NUM_BARS];
    logic [NUM_BARS-1:0] match_vec;

    cfg_access_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_req   (cfg_req),
        .cfg_we    (cfg_we),
        .cfg_dw    (cfg_dw),
        .cfg_wdata (cfg_wdata),
        .rd_word   (rd_word),
        .lat_dw    (lat_dw),
        .lat_wdata (lat_wdata),
        .wr_stb    (wr_stb),
        .cfg_ack   (cfg_ack),
        .cfg_rdata (cfg_rdata)
    );

    // command register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_en_q  <= 1'b0;
            mem_en_q <= 1'b0;
        end else if (wr_stb && lat_dw == CMD_DW_IDX) begin
            io_en_q  <= lat_wdata[CMD_IO_BIT];
            mem_en_q <= lat_wdata[CMD_MEM_BIT];
        end
    end

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        localparam int unsigned SZ = int'(BAR_LOG2[g*LOG2_FW +: LOG2_FW]);
        localparam logic [DW_IDX_W-1:0] MY_DW = BAR0_DW_IDX + DW_IDX_W'(g);

        logic wr_en;
        assign wr_en = wr_stb && (lat_dw == MY_DW);

        cfg_bar_slot #(
            .IS_IO     (BAR_IO_MASK[g]),
            .SIZE_LOG2 (SZ)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .wdata     (lat_wdata),
            .rd_val    (bar_rd[g]),
            .acc_valid (acc_valid),
            .acc_is_io (acc_is_io),
            .acc_addr  (acc_addr),
            .space_en  (BAR_IO_MASK[g] ? io_en_q : mem_en_q),
            .match     (match_vec[g])
        );
    end

    // read mux; unimplemented offsets return zero
    always_comb begin
        rd_word = '0;
        if (lat_dw == CMD_DW_IDX) begin
            rd_word[CMD_IO_BIT]  = io_en_q;
            rd_word[CMD_MEM_BIT] = mem_en_q;
        end
        for (int i = 0; i < NUM_BARS; i++) begin
            if (lat_dw == BAR0_DW_IDX + DW_IDX_W'(i)) rd_word = bar_rd[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bar_hit <= '0;
        else        bar_hit <= match_vec;
    end

endmodule

// File: rtl/cfg_bar_decode_chk.sv
module cfg_bar_decode_chk #(
    parameter int unsigned         NUM_BARS    = 3,
    parameter logic [NUM_BARS-1:0] BAR_IO_MASK = 3'b010
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_valid,
    input logic                acc_is_io,
    input logic [NUM_BARS-1:0] bar_hit,
    input logic                cfg_ack,
    input logic                io_en,
    input logic                mem_en
);

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (bar_hit == '0)); // R9

    AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_is_io && !mem_en) |=> (bar_hit == '0)); // R8

    AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_io && !io_en) |=> (bar_hit == '0)); // R8

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |=> !cfg_ack); // R10

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_ty
        AST_HIT_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
            bar_hit[g] |-> ($past(acc_is_io) == BAR_IO_MASK[g])); // R6
    end

endmodule

bind cfg_bar_decode cfg_bar_decode_chk #(
    .NUM_BARS    (NUM_BARS),
    .BAR_IO_MASK (BAR_IO_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_is_io (acc_is_io),
    .bar_hit   (bar_hit),
    .cfg_ack   (cfg_ack),
    .io_en     (io_en_q),
    .mem_en    (mem_en_q)
);

// File: tb/cfg_bar_decode_test.sv
module cfg_bar_decode_test;

    localparam int NB = 3;
    localparam logic [NB-1:0] IO_MASK = 3'b010;
    localparam int SZ [NB] = '{8, 4, 12};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_dw = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_ack;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_is_io = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [NB-1:0] bar_hit;

    int checks = 0;
    int fails = 0;
    logic [31:0] base_m [NB];
    logic        io_en_m = 1'b0;
    logic        mem_en_m = 1'b0;

    always #10 clk = ~clk;

    cfg_bar_decode #(
        .NUM_BARS    (NB),
        .BAR_IO_MASK (IO_MASK),
        .BAR_LOG2    ({5'd12, 5'd4, 5'd8})
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_dw(cfg_dw), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
        .cfg_rdata(cfg_rdata), .acc_valid(acc_valid), .acc_is_io(acc_is_io),
        .acc_addr(acc_addr), .bar_hit(bar_hit)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic cfg_xfer(input bit we, input logic [5:0] dw, input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = we; cfg_dw = dw; cfg_wdata = wd;
        @(negedge clk);
        cfg_req = 1'b0;
        if (cfg_ack) chk(1'b0, "R10 early ack", 32'(cfg_ack), 32'd0);
        @(negedge clk);
        chk(cfg_ack == 1'b1, "R10 ack latency", 32'(cfg_ack), 32'd1);
        rd = cfg_rdata;
    endtask

    task automatic cfg_wr(input logic [5:0] dw, input logic [31:0] wd);
        logic [31:0] dummy;
        cfg_xfer(1'b1, dw, wd, dummy);
    endtask

    task automatic cfg_rd_chk(input logic [5:0] dw, input logic [31:0] exp, input string req);
        logic [31:0] got;
        cfg_xfer(1'b0, dw, 32'd0, got);
        chk(got == exp, req, got, exp);
    endtask

    function automatic logic [NB-1:0] exp_hit(input bit v, input bit io, input logic [31:0] a);
        logic [NB-1:0] h = '0;
        for (int i = 0; i < NB; i++) begin
            bit en = IO_MASK[i] ? io_en_m : mem_en_m;
            if (v && en && (io == IO_MASK[i]) && ((a >> SZ[i]) == (base_m[i] >> SZ[i])))
                h[i] = 1'b1;
        end
        return h;
    endfunction

    task automatic probe(input bit v, input bit io, input logic [31:0] a, input string req);
        logic [NB-1:0] e;
        @(negedge clk);
        acc_valid = v; acc_is_io = io; acc_addr = a;
        e = exp_hit(v, io, a);
        @(negedge clk);
        acc_valid = 1'b0;
        chk(bar_hit == e, req, 32'(bar_hit), 32'(e));
    endtask

    function automatic logic [31:0] ones_mask(input int i);
        return (32'hFFFF_FFFF << SZ[i]) | (IO_MASK[i] ? 32'd1 : 32'd0);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] saved;
        logic [31:0] got;
        logic [31:0] a;
        for (int i = 0; i < NB; i++) base_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bar_hit == '0, "R9 reset hit", 32'(bar_hit), 32'd0);
        chk(cfg_ack == 1'b0, "R10 reset ack", 32'(cfg_ack), 32'd0);

        // R1: reset value and readback
        cfg_rd_chk(6'd1, 32'd0, "R1 command reset");
        probe(1'b1, 1'b0, 32'd0, "R8 disabled after reset");
        cfg_wr(6'd1, 32'hFFFF_FFFF);
        io_en_m = 1'b1; mem_en_m = 1'b1;
        cfg_rd_chk(6'd1, 32'd3, "R1 command ones readback");

        // R3 R4: probes of type and size
        for (int i = 0; i < NB; i++) begin
            cfg_wr(6'(4 + i), 32'hFFFF_FFFF);
            cfg_rd_chk(6'(4 + i), ones_mask(i), "R4 size mask");
            cfg_wr(6'(4 + i), 32'h0000_0000);
            cfg_rd_chk(6'(4 + i), IO_MASK[i] ? 32'd1 : 32'd0, "R3 type bits");
        end

        // program bases
        base_m[0] = 32'h8000_0100;
        base_m[1] = 32'h0000_C010;
        base_m[2] = 32'h8000_2000;
        for (int i = 0; i < NB; i++) begin
            cfg_wr(6'(4 + i), base_m[i]);
            cfg_rd_chk(6'(4 + i), base_m[i] | (IO_MASK[i] ? 32'd1 : 32'd0), "R5 base readback");
        end

        // R2: unimplemented offsets
        for (int d = 0; d < 64; d++) begin
            if (d == 1 || (d >= 4 && d < 4 + NB)) continue;
            cfg_wr(6'(d), 32'hFFFF_FFFF);
            cfg_rd_chk(6'(d), 32'd0, "R2 unimplemented reads zero");
        end
        cfg_wr(6'd1, 32'd0);
        io_en_m = 1'b0; mem_en_m = 1'b0;
        cfg_wr(6'd63, 32'hFFFF_FFFF);
        cfg_wr(6'd9, 32'hFFFF_FFFF);
        cfg_rd_chk(6'd1, 32'd0, "R2 command untouched");
        for (int i = 0; i < NB; i++)
            cfg_rd_chk(6'(4 + i), base_m[i] | (IO_MASK[i] ? 32'd1 : 32'd0), "R2 BAR untouched");

        // R6 R7 R8: decode sweep over enables, spaces and window edges
        for (int en = 0; en < 4; en++) begin
            cfg_wr(6'd1, 32'(en));
            io_en_m = en[0]; mem_en_m = en[1];
            for (int i = 0; i < NB; i++) begin
                for (int o = 0; o < 5; o++) begin
                    int sz = 1 << SZ[i];
                    int off = (o == 0) ? -1 : (o == 1) ? 0 : (o == 2) ? sz / 2 : (o == 3) ? sz - 1 : sz;
                    a = base_m[i] + 32'(off);
                    for (int sp = 0; sp < 2; sp++)
                        probe(1'b1, sp[0], a, sp[0] ? "R7 io decode" : "R6 mem decode");
                end
            end
        end

        // R9: no hit without valid
        probe(1'b0, 1'b0, base_m[0], "R9 no valid");
        probe(1'b0, 1'b1, base_m[1], "R9 no valid io");

        // R5: save, probe, restore on each BAR
        for (int i = 0; i < NB; i++) begin
            cfg_xfer(1'b0, 6'(4 + i), 32'd0, saved);
            cfg_wr(6'(4 + i), 32'hFFFF_FFFF);
            cfg_rd_chk(6'(4 + i), ones_mask(i), "R4 probe mask");
            cfg_wr(6'(4 + i), saved);
            cfg_xfer(1'b0, 6'(4 + i), 32'd0, got);
            chk(got == saved, "R5 restore readback", got, saved);
            probe(1'b1, IO_MASK[i], base_m[i], "R5 restored decode");
            probe(1'b1, IO_MASK[i], base_m[i] + 32'((1 << SZ[i]) - 1), "R5 restored end");
            probe(1'b1, IO_MASK[i], base_m[i] + 32'(1 << SZ[i]), "R5 restored past end");
        end

        report();
    end

endmodule